// File: doc/BRIEF.md
# Distance-Coded Safe Sequencer

This block is a small sequencing state machine whose state register holds only code words of a distance code. The machine steps through a numbered chain of phases. `go` starts the chain from idle, `step` advances it one phase at a time, and `abort` returns it to idle. Every legal phase has its own code word, so any value of the register that is not a code word is caught by a decoder. When that happens the machine drops into a sticky fault condition with all functional outputs forced inactive, and it stays there until reset.

The parameter `PROT` selects how strongly the state is protected:

- 0: plain binary index.
- 1: index plus an even parity bit.
- 2: a shortened single-error Hamming code.
- 3: that Hamming code extended by an overall parity bit.

The smallest distance between any two legal codes is then 1, 2, 3 or 4 bits. The `inj_mask` input XORs a pattern into the state register. This lets a test prove, while the chip is running, that the detection path works.

Top module: `hsfsm_top`

## Requirements
- R1: While `rst` is high at a clock edge, the state returns to phase 0 and `busy_o`, `phase_o`, `done_o` and `err_o` are all 0 after that edge.
- R2: In phase 0, a `go` without `abort` moves to phase 1 at the next edge. `go` has no effect outside phase 0, and `step` has no effect in phase 0.
- R3: In phases 1 to NUM_ST-2, `step` without `abort` moves to the next higher phase at the next edge. With no event asserted, the phase holds.
- R4: In phase NUM_ST-1, `step` moves to phase 0 and raises `done_o` for exactly one cycle.
- R5: `abort` has priority over `go` and `step`, and sends any non-fault state to phase 0 at the next edge.
- R6: All outputs are registered. `busy_o` is 1 exactly when `phase_o` is non-zero.
- R7: State codes depend on `PROT`:
  - `PROT`=0: the binary index.
  - `PROT`=1: the index with an even-parity bit above it.
  - `PROT`=2: a Hamming word in which bit i holds code position i+1. Parity sits at positions 1, 2, 4 and 8, and the index bits fill the other positions, low bit first. With eight phases, phases 0 to 7 encode as 000000, 000111, 011001, 011110, 101010, 101101, 110011 and 110100.
  - `PROT`=3: the `PROT`=2 word with an overall parity bit added on top.
- R8: A state register value that is not a legal code sets `err_o` at the next edge. While `err_o` is 1, `busy_o`, `phase_o` and `done_o` are 0.
- R9: `err_o` is sticky. Once it is set, `go`, `step`, `abort` and `inj_mask` change no output until reset.
- R10: A non-zero `inj_mask` is XORed into the state register at the edge that loads the next state. `err_o` stays 0 at that edge. It rises at the following edge whenever the mask has fewer set bits than the minimum code distance.
- R11: A reset after a fault clears `err_o`, and the machine then accepts `go` normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start event, acted on in phase 0 |
| step | input | 1 | Advance event |
| abort | input | 1 | Return-to-idle event, highest priority |
| inj_mask | input | SW | Fault injection pattern XORed into the state register |
| busy_o | output | 1 | Sequence running (phase non-zero) |
| phase_o | output | IW | Current phase index |
| done_o | output | 1 | One-cycle pulse on wrap from the last phase |
| err_o | output | 1 | Sticky illegal-state flag |

## Verification
The event walk covers several distinct cases:
- `step` in idle and `go` outside idle, which are ignored.
- A full climb through all eight phases with the wrap pulse, which separates an off-by-one last phase from a correct one.
- `abort` combined with each of the other events, which exposes a wrong priority order.

On the fault side, a single-bit flip is tried at every bit position, and a double-bit flip tests the distance-3 code. These separate a missing or partial code check from a full one. Checking `err_o` both at the injecting edge and one edge later pins the detection latency. Events applied after the fault, and a reset afterwards, show that the fault is sticky and that reset clears it.

// File: rtl/hsfsm_pkg.sv
package hsfsm_pkg;

  // bits needed for a state index
  function automatic int idx_width(input int ns);
    return (ns <= 2) ? 1 : $clog2(ns);
  endfunction

  // shortened Hamming length for k data bits
  function automatic int ham_len(input int k);
    int len;
    len = k + 1;
    for (int r = 1; r < 8; r++) begin
      if ((1 << r) >= k + r + 1) begin
        len = k + r;
        break;
      end
    end
    return len;
  endfunction

  function automatic int code_width(input int prot, input int ns);
    int k;
    k = idx_width(ns);
    case (prot)
      0:       return k;
      1:       return k + 1;
      2:       return ham_len(k);
      default: return ham_len(k) + 1;
    endcase
  endfunction

  function automatic int min_dist(input int prot);
    return prot + 1;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/hsfsm_encode.sv
module hsfsm_encode #(
  parameter int PROT = 2,
  parameter int IW   = 3,
  parameter int SW   = 6
) (
  input  logic [IW-1:0] idx,
  output logic [SW-1:0] code
);
  import hsfsm_pkg::*;

  localparam int HL = ham_len(IW);

  generate
    if (PROT == 0) begin : g_bin
      assign code = idx;
    end else if (PROT == 1) begin : g_par
      assign code = {^idx, idx};
    end else begin : g_ham
      logic [HL-1:0] hw;
      always_comb begin
        int d;
        logic acc;
        hw = '0;
        d  = 0;
        for (int pos = 1; pos <= HL; pos++) begin
          if (!is_pow2(pos)) begin
            hw[pos-1] = idx[d];
            d++;
          end
        end
        for (int p = 1; p <= HL; p++) begin
          if (is_pow2(p)) begin
            acc = 1'b0;
            for (int q = 1; q <= HL; q++) begin
              if (((q & p) != 0) && (q != p)) acc = acc ^ hw[q-1];
            end
            hw[p-1] = acc;
          end
        end
      end
      if (PROT == 2) begin : g_sec
        assign code = hw;
      end else begin : g_ext
        assign code = {^hw, hw};
      end
    end
  endgenerate

endmodule

// File: rtl/hsfsm_decode.sv
module hsfsm_decode #(
  parameter int PROT   = 2,
  parameter int NUM_ST = 8,
  parameter int IW     = 3,
  parameter int SW     = 6
) (
  input  logic [SW-1:0] state_code,
  output logic [IW-1:0] idx,
  output logic          legal
);

  logic [NUM_ST-1:0] hit;

  generate
    for (genvar s = 0; s < NUM_ST; s++) begin : g_cmp
      logic [SW-1:0] ref_code;
      hsfsm_encode #(.PROT(PROT), .IW(IW), .SW(SW)) u_ref (
        .idx  (IW'(s)),
        .code (ref_code)
      );
      assign hit[s] = (state_code == ref_code);
    end
  endgenerate

  always_comb begin
    idx   = '0;
    legal = 1'b0;
    for (int s = 0; s < NUM_ST; s++) begin
      if (hit[s]) begin
        idx   = IW'(s);
        legal = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hsfsm_step.sv
module hsfsm_step #(
  parameter int NUM_ST = 8,
  parameter int IW     = 3
) (
  input  logic [IW-1:0] cur,
  input  logic          go,
  input  logic          step,
  input  logic          abort,
  output logic [IW-1:0] nxt,
  output logic          wrap
);

  localparam logic [IW-1:0] LAST = IW'(NUM_ST - 1);

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (abort) begin
      nxt = '0;
    end else if (cur == '0) begin
      if (go) nxt = IW'(1);
    end else if (step) begin
      if (cur == LAST) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = cur + IW'(1);
      end
    end
  end

endmodule

// File: rtl/hsfsm_top.sv
module hsfsm_top #(
  parameter int PROT   = 2,
  parameter int NUM_ST = 8,
  localparam int IW    = hsfsm_pkg::idx_width(NUM_ST),
  localparam int SW    = hsfsm_pkg::code_width(PROT, NUM_ST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          step,
  input  logic          abort,
  input  logic [SW-1:0] inj_mask,
  output logic          busy_o,
  output logic [IW-1:0] phase_o,
  output logic          done_o,
  output logic          err_o
);

  logic [SW-1:0] state_q;
  logic [SW-1:0] nxt_code;
  logic [SW-1:0] rst_code;
  logic [IW-1:0] cur_idx;
  logic [IW-1:0] nxt_idx;
  logic          legal;
  logic          wrap;
  logic          ok;

  hsfsm_decode #(.PROT(PROT), .NUM_ST(NUM_ST), .IW(IW), .SW(SW)) u_dec (
    .state_code (state_q),
    .idx        (cur_idx),
    .legal      (legal)
  );

  hsfsm_step #(.NUM_ST(NUM_ST), .IW(IW)) u_step (
    .cur   (cur_idx),
    .go    (go),
    .step  (step),
    .abort (abort),
    .nxt   (nxt_idx),
    .wrap  (wrap)
  );

  hsfsm_encode #(.PROT(PROT), .IW(IW), .SW(SW)) u_enc_nxt (
    .idx  (nxt_idx),
    .code (nxt_code)
  );

  hsfsm_encode #(.PROT(PROT), .IW(IW), .SW(SW)) u_enc_rst (
    .idx  ('0),
    .code (rst_code)
  );

  // a fault or an illegal word takes the default path: freeze and flag
  assign ok = !err_o && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= rst_code;
      err_o   <= 1'b0;
      busy_o  <= 1'b0;
      phase_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (ok) state_q <= nxt_code ^ inj_mask;
      err_o   <= err_o | !legal;
      busy_o  <= ok && (nxt_idx != '0);
      phase_o <= ok ? nxt_idx : '0;
      done_o  <= ok && wrap;
    end
  end

endmodule

// File: rtl/hsfsm_chk.sv
module hsfsm_chk #(
  parameter int PROT   = 2,
  parameter int NUM_ST = 8,
  localparam int IW    = hsfsm_pkg::idx_width(NUM_ST),
  localparam int SW    = hsfsm_pkg::code_width(PROT, NUM_ST)
) (
  input logic          clk,
  input logic          rst,
  input logic          abort,
  input logic [SW-1:0] inj_mask,
  input logic          legal,
  input logic          busy_o,
  input logic [IW-1:0] phase_o,
  input logic          done_o,
  input logic          err_o
);

  localparam int HD = hsfsm_pkg::min_dist(PROT);
  localparam logic [IW-1:0] LAST = IW'(NUM_ST - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!err_o && !busy_o && phase_o == '0 && !done_o));

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(phase_o) == LAST && phase_o == '0));

  a_r5_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (abort && legal && !err_o) |=> (phase_o == '0));

  a_r6_busy_phase: assert property (@(posedge clk) disable iff (rst)
    busy_o == (phase_o != '0));

  a_r8_illegal_flagged: assert property (@(posedge clk) disable iff (rst)
    (!legal && !err_o) |=> err_o);

  a_r8_safe_outputs: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && phase_o == '0 && !done_o));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  a_r10_inject_detected: assert property (@(posedge clk) disable iff (rst)
    (!err_o && legal && inj_mask != '0 && $countones(inj_mask) < HD)
      |=> ##1 err_o);

endmodule

bind hsfsm_top hsfsm_chk #(.PROT(PROT), .NUM_ST(NUM_ST)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .abort    (abort),
  .inj_mask (inj_mask),
  .legal    (legal),
  .busy_o   (busy_o),
  .phase_o  (phase_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/hsfsm_top_tb_top.sv
module hsfsm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  // {go, step, abort, busy, phase[2:0], done}
  localparam logic [7:0] VEC [NV] = '{
    8'b01000000, 8'b10010010, 8'b10010010, 8'b00010010,
    8'b01010100, 8'b01010110, 8'b01011000, 8'b01011010,
    8'b01011100, 8'b01011110, 8'b01000001, 8'b00000000,
    8'b10010010, 8'b01010100, 8'b01100000, 8'b10100000,
    8'b10010010
  };
  localparam string TAG [NV] = '{
    "R2", "R2", "R2", "R3", "R3", "R3", "R3", "R3",
    "R3", "R3", "R4", "R4", "R2", "R3", "R5", "R5", "R2"
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go = 1'b0, step = 1'b0, abort = 1'b0;
  logic [5:0] inj_mask = '0;
  logic       busy_o, done_o, err_o;
  logic [2:0] phase_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsfsm_top dut_i (
    .clk(clk), .rst(rst), .go(go), .step(step), .abort(abort),
    .inj_mask(inj_mask), .busy_o(busy_o), .phase_o(phase_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change at the falling edge; one rising edge then passes
  task automatic apply(input logic g, input logic s, input logic a,
                       input logic [5:0] m);
    go = g; step = s; abort = a; inj_mask = m;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    apply(0, 0, 0, '0);
    apply(0, 0, 0, '0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    apply(0, 0, 0, '0);
    apply(0, 0, 0, '0);
    // R1: outputs after reset edges
    check("R1 busy", busy_o, 0);
    check("R1 phase", phase_o, 0);
    check("R1 done", done_o, 0);
    check("R1 err", err_o, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][7], VEC[i][6], VEC[i][5], '0);
      check({TAG[i], " phase"}, phase_o, VEC[i][3:1]);
      check({TAG[i], " busy"}, busy_o, VEC[i][4]);
      check({TAG[i], " done"}, done_o, VEC[i][0]);
      check("R6 busy vs phase", busy_o, (phase_o != 0) ? 1 : 0);
    end

    // R10: single-bit injection in phase 1, not flagged on the injecting edge
    apply(0, 0, 0, 6'b000001);
    check("R10 no early err", err_o, 0);
    check("R10 phase held", phase_o, 1);
    apply(0, 0, 0, '0);
    check("R10 err raised", err_o, 1);
    check("R8 busy safe", busy_o, 0);
    check("R8 phase safe", phase_o, 0);
    check("R8 done safe", done_o, 0);

    // R9: events after the fault change nothing
    apply(1, 0, 0, '0);
    check("R9 go ignored err", err_o, 1);
    check("R9 go ignored phase", phase_o, 0);
    apply(0, 1, 1, 6'b000010);
    check("R9 step/abort/inj err", err_o, 1);
    check("R9 busy", busy_o, 0);

    // R11: reset clears the fault and the machine runs again
    do_reset();
    check("R11 err cleared", err_o, 0);
    check("R11 phase", phase_o, 0);
    apply(1, 0, 0, '0);
    check("R11 go accepted", phase_o, 1);

    // R7: distance-3 code catches a double flip
    do_reset();
    apply(0, 0, 0, 6'b100001);
    check("R7 double no early err", err_o, 0);
    apply(0, 0, 0, '0);
    check("R7 double flip detected", err_o, 1);

    // R10: every single bit position, injected while stepping 3 -> 4
    for (int b = 0; b < 6; b++) begin
      do_reset();
      apply(1, 0, 0, '0);
      apply(0, 1, 0, '0);
      apply(0, 1, 0, '0);
      apply(0, 1, 0, 6'(1 << b));
      check("R10 inject edge phase", phase_o, 4);
      apply(0, 0, 0, '0);
      check("R10 bit detected", err_o, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule